// File: doc/BRIEF.md
# Low-Side Control Mode Detector

This block watches a slow, asynchronous control pin and decides whether the gate sequencer of a half bridge should drive the low-side switch synchronously with the high side. It recognises three input conditions. A level held high means synchronous switching. A level held low means only the high side is driven. A pin that toggles faster than a configured band limit is also read as a request for synchronous switching.

The pin passes through a synchronizer and an edge detector. A cycle counter measures the spacing between synchronized edges. Toggling is declared only after two consecutive edge intervals fall inside the band. Once the edges stop, the toggling decision is held for a filter time. Only after that does the settled level take over the meaning of the pin. While the pin is neither validly toggling nor settled, the mode output keeps its previous value. All limits are parameters counted in clock cycles. The defaults suit a 125 MHz clock: a band limit of about 0.72 MHz, which is 87 cycles between edges, and a filter time of 3 us, which is 375 cycles.

Top module: `lsd_mode_detect`

## Requirements
- R1: A pin level of 1 held with no synchronized edge for FILT_CYC cycles sets ls_sync_en_o to 1. After a single pin change, the output takes the new level on the (FILT_CYC+4)-th rising clock edge after the change, and not earlier.
- R2: A pin level of 0 held with no synchronized edge for FILT_CYC cycles sets ls_sync_en_o to 0, with the same timing as R1.
- R3: When the pin toggles with every edge spacing of at most BAND_CYC cycles, toggle_seen_o and ls_sync_en_o are 1 from the third rising clock edge after the pin change that completes the second in-band interval.
- R4: Edges spaced BAND_CYC+1 cycles or more apart never declare toggling. A spacing of exactly BAND_CYC cycles does count as in band.
- R5: After the last in-band edge, toggle_seen_o stays 1 for FILT_CYC+3 rising clock edges after the pin change and falls on the next one.
- R6: A single in-band interval, such as one short pulse, does not declare toggling. The first edge after reset does not open an interval.
- R7: While the pin is neither declared toggling nor settled for FILT_CYC cycles, ls_sync_en_o holds its previous value. This applies to slow toggling and to a fresh level change.
- R8: During reset and after it, both outputs are 0. ls_sync_en_o stays 0 until the pin has settled or validly toggled, even if the pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lscon_i | input | 1 | Asynchronous low-side control pin |
| ls_sync_en_o | output | 1 | 1: synchronous low-side switching enabled, 0: high side only |
| toggle_seen_o | output | 1 | 1 while the pin is treated as validly toggling |

## Verification
Two things are hardest to reach from the ports: the exact band boundary, and the point where a toggling decision expires on the same cycle as the level settles. Both depend on edge spacing counted through the two-flop synchronizer. The stimulus drives the pin on falling clock edges with spacings of exactly BAND_CYC and BAND_CYC+1 cycles. It then counts falling edges from the last pin change to sample toggle_seen_o and ls_sync_en_o on both sides of the expiry cycle. This is done once with the pin ending high and once ending low, so the hold of R7 is distinguished from the settle of R1 and R2.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  typedef struct packed {
    logic lvl;
    logic edge_seen;
  } sync_t;

  typedef enum logic [1:0] {
    RUN_IDLE,
    RUN_ONE,
    RUN_TWO
  } run_e;
endpackage

// File: rtl/lsd_sync.sv
module lsd_sync #(
  parameter int STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pin_i,
  output lsd_pkg::sync_t sync_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= chain_q[STAGES-1];

  assign sync_o.lvl       = chain_q[STAGES-1];
  assign sync_o.edge_seen = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/lsd_interval.sv
module lsd_interval #(
  parameter int BAND_CYC = 87,
  parameter int FILT_CYC = 375
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic in_band_o,
  output logic past_band_o,
  output logic settled_o
);
  localparam int CNT_W = $clog2(FILT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FILT_CYC);
  localparam logic [CNT_W-1:0] BAND_LIM = CNT_W'(BAND_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  // cycles since last synchronized edge, saturating at the filter time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (edge_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign in_band_o   = armed_q && (cnt_q < BAND_LIM);
  assign past_band_o = cnt_q >= BAND_LIM;
  assign settled_o   = cnt_q == CNT_MAX;

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  p_settle_kept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled_o && !edge_i) |=> settled_o);
  p_edge_leaves_band_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> !settled_o);
endmodule

// File: rtl/lsd_qualify.sv
module lsd_qualify
  import lsd_pkg::*;
#(
  parameter int FILT_CYC = 375
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic lvl_i,
  input  logic in_band_i,
  input  logic past_band_i,
  input  logic settled_i,
  output logic tog_o,
  output logic en_o
);
  localparam int CNT_W = $clog2(FILT_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_MAX = CNT_W'(FILT_CYC);

  run_e             run_q, run_d;
  logic [CNT_W-1:0] hold_q;
  logic             tog_q, en_q;
  logic             qual_edge, tog_d, en_d, quiet_lvl;

  always_comb begin
    run_d = run_q;
    if (edge_i) begin
      if (!in_band_i)            run_d = RUN_IDLE;
      else if (run_q == RUN_IDLE) run_d = RUN_ONE;
      else                       run_d = RUN_TWO;
    end else if (past_band_i) begin
      run_d = RUN_IDLE;
    end
  end

  // second consecutive in-band interval (or later) qualifies
  assign qual_edge = edge_i && in_band_i && (run_q != RUN_IDLE);
  assign quiet_lvl = settled_i && !edge_i;
  assign tog_d     = qual_edge || (tog_q && (hold_q != HOLD_MAX));
  assign en_d      = tog_d ? 1'b1 : (quiet_lvl ? lvl_i : en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= RUN_IDLE;
      hold_q <= HOLD_MAX;
      tog_q  <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      run_q <= run_d;
      tog_q <= tog_d;
      en_q  <= en_d;
      if (qual_edge)              hold_q <= '0;
      else if (hold_q != HOLD_MAX) hold_q <= hold_q + 1'b1;
    end
  end

  assign tog_o = tog_q;
  assign en_o  = en_q;

  p_tog_forces_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tog_q |-> en_q);
  p_qual_sets_tog_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && in_band_i && run_q != RUN_IDLE) |=> tog_q);
  p_slow_edge_no_tog_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && !in_band_i && !tog_q) |=> !tog_q);
  p_hold_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tog_q && hold_q != HOLD_MAX) |=> tog_q);
  p_two_intervals_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tog_q) |-> $past(edge_i && run_q != RUN_IDLE));
  p_en_moves_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_q) |-> (tog_q || $past(settled_i && !edge_i)));
endmodule

// File: rtl/lsd_mode_detect.sv
module lsd_mode_detect #(
  parameter int BAND_CYC    = 87,
  parameter int FILT_CYC    = 375,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lscon_i,
  output logic ls_sync_en_o,
  output logic toggle_seen_o
);
  lsd_pkg::sync_t sync_w;
  logic in_band_w, past_band_w, settled_w;

  lsd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (lscon_i),
    .sync_o (sync_w)
  );

  lsd_interval #(.BAND_CYC(BAND_CYC), .FILT_CYC(FILT_CYC)) u_interval (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .edge_i      (sync_w.edge_seen),
    .in_band_o   (in_band_w),
    .past_band_o (past_band_w),
    .settled_o   (settled_w)
  );

  lsd_qualify #(.FILT_CYC(FILT_CYC)) u_qualify (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .edge_i      (sync_w.edge_seen),
    .lvl_i       (sync_w.lvl),
    .in_band_i   (in_band_w),
    .past_band_i (past_band_w),
    .settled_i   (settled_w),
    .tog_o       (toggle_seen_o),
    .en_o        (ls_sync_en_o)
  );

  p_reset_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_sync_en_o) |-> ($past(settled_w) || toggle_seen_o));
endmodule

// File: tb/lsd_mode_detect_test.sv
module lsd_mode_detect_test;
  localparam int BAND = 87;
  localparam int FILT = 375;

  logic clk_i = 1'b0, rst_ni = 1'b0, lscon_i = 1'b0;
  logic ls_sync_en_o, toggle_seen_o;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #4 clk_i = ~clk_i;

  lsd_mode_detect #(.BAND_CYC(BAND), .FILT_CYC(FILT)) uut (
    .clk_i, .rst_ni, .lscon_i, .ls_sync_en_o, .toggle_seen_o
  );

  // columns: edge spacing, edge count, extra wait, expected toggle, expected enable
  localparam int NV = 9;
  localparam int VEC [NV][5] = '{
    '{20,  8, 10,        1, 1},  // R3
    '{BAND, 4, 10,       1, 1},  // R4 edge of band
    '{BAND+1, 8, 10,     0, 0},  // R4 just outside
    '{10,  2, 10,        0, 0},  // R6 single pulse
    '{10,  3, 10,        1, 1},  // R6 two intervals
    '{20,  6, FILT+20,   0, 0},  // R5 R2 ends low
    '{20,  7, FILT+20,   0, 1},  // R5 R1 ends high
    '{200, 1, FILT+20,   0, 1},  // R1 static high
    '{300, 3, 20,        0, 0}   // R7 slow edges hold
  };

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(logic pin);
    rst_ni  = 1'b0;
    lscon_i = pin;
    step(3);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    step(100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    step(1);
    // R8 reset state
    rst_ni = 1'b0;
    step(2);
    chk("R8 en in reset", ls_sync_en_o, 1'b0);
    chk("R8 tog in reset", toggle_seen_o, 1'b0);

    for (int v = 0; v < NV; v++) begin
      do_reset(1'b0);
      step(20);
      for (int e = 0; e < VEC[v][1]; e++) begin
        lscon_i = ~lscon_i;
        step(VEC[v][0]);
      end
      step(VEC[v][2]);
      chk($sformatf("R3/R4/R5/R6 tog vec%0d", v), toggle_seen_o, 1'(VEC[v][3]));
      chk($sformatf("R1/R2/R7 en vec%0d", v), ls_sync_en_o, 1'(VEC[v][4]));
    end

    // R3 exact latency and R5 exact expiry, ending high
    do_reset(1'b0);
    step(20);
    lscon_i = 1'b1; step(10);
    lscon_i = 1'b0; step(10);
    lscon_i = 1'b1; step(2);
    chk("R3 not yet", toggle_seen_o, 1'b0);
    step(1);
    chk("R3 tog set", toggle_seen_o, 1'b1);
    chk("R3 en set", ls_sync_en_o, 1'b1);
    step(FILT);
    chk("R5 tog held", toggle_seen_o, 1'b1);
    step(1);
    chk("R5 tog expired", toggle_seen_o, 1'b0);
    chk("R1 high keeps en", ls_sync_en_o, 1'b1);

    // R7 hold then R2 settle after a single fall
    lscon_i = 1'b0;
    step(FILT + 3);
    chk("R7 en held", ls_sync_en_o, 1'b1);
    step(1);
    chk("R2 en cleared", ls_sync_en_o, 1'b0);

    // R1 exact settle after a single rise
    lscon_i = 1'b1;
    step(FILT + 3);
    chk("R1 not yet", ls_sync_en_o, 1'b0);
    step(1);
    chk("R1 en set", ls_sync_en_o, 1'b1);

    // R8 pin high through reset
    do_reset(1'b1);
    step(FILT / 2);
    chk("R8 en low while unsettled", ls_sync_en_o, 1'b0);
    chk("R8 tog low", toggle_seen_o, 1'b0);
    step(FILT);
    chk("R1 en after settle", ls_sync_en_o, 1'b1);

    // R7 slow toggling leaves enable at 1
    for (int e = 0; e < 4; e++) begin
      lscon_i = ~lscon_i;
      step(BAND + 40);
      chk("R7 slow edges hold en", ls_sync_en_o, 1'b1);
      chk("R4 slow edges no tog", toggle_seen_o, 1'b0);
    end

    // R8 reset during toggling
    for (int e = 0; e < 6; e++) begin
      lscon_i = ~lscon_i;
      step(15);
    end
    chk("R3 toggling before reset", toggle_seen_o, 1'b1);
    rst_ni = 1'b0;
    step(1);
    chk("R8 tog cleared by reset", toggle_seen_o, 1'b0);
    chk("R8 en cleared by reset", ls_sync_en_o, 1'b0);
    rst_ni = 1'b1;
    step(5);
    finish_run();
  end
endmodule